// File: doc/BRIEF.md
# Dual-Row Layered LDPC Posterior Update Core

This block is the bit-node update and scheduling engine of a layered min-sum LDPC decoder. The parity-check matrix is made of Z-by-Z blocks. Each block is either empty or an identity matrix rotated by a per-block amount, and those amounts come from a parameter table. The core keeps the posterior log-likelihood of every code bit and the last check-to-bit message of every check row.

For each step it processes two block rows together: row p and row p+MB/2. It reads one block column per cycle and rotates the posterior vector into check order. It subtracts each row's previous message and collects running min-sum statistics for both rows. A second sweep over the columns then produces the new messages. It rotates the two corrections back into bit order and adds both into a single saturated posterior write.

Software loads channel LLRs column by column while the core is idle. It sets an iteration count and pulses start. After a one-cycle done strobe it reads posteriors and hard decisions.

The sequencer has five states:
- SEQ_IDLE: waiting.
- SEQ_GATHER: first column sweep.
- SEQ_APPLY: second column sweep, with write-back.
- SEQ_ADVANCE: moves to the next pair or iteration.
- SEQ_DONE: strobe.

Its transitions are:
- idle-to-gather on start with a nonzero count.
- idle-to-done on start with a zero count.
- gather-to-apply after the last column.
- apply-to-advance after the last column.
- advance-to-gather while pairs or iterations remain.
- advance-to-done after the final pair of the final iteration.
- done-to-idle unconditionally.

Top module: `ldpc_dual_layer_core`

## Requirements
- R1: After reset, busy, done and every hard-decision bit are 0, and every posterior reads back as 0.
- R2: While idle, a cycle with load_en high writes load_data into posterior column load_col, with lane k in bits [k*W +: W] in two's complement. rd_data shows column rd_col combinationally in the same layout.
- R3: While busy, load_en has no effect on any posterior.
- R4: A start with iter_count = 0 gives done in the cycle right after the start edge, and all posteriors are left unchanged.
- R5: Pairs are processed as (0, MB/2), (1, MB/2+1), ... in ascending order, once per iteration. Each pair takes 2*NB+1 cycles, so done rises exactly iter_count*(MB/2)*(2*NB+1) cycles after the start edge. done lasts one cycle, busy is high from the start edge through the done cycle, and busy is 0 the cycle after done.
- R6: Block (r,j) with shift s >= 0 connects check row k to bit (k+s) mod Z of column j. A shift of -1 means no connection. The bit-to-check message is sat(posterior - previous message of that row).
- R7: A new check-to-bit message has a magnitude equal to the smallest |message| among the other connected columns of that check row, or 31 if there are none. Its sign is the XOR of those other messages' signs, where a negative value has sign 1 and zero counts as positive.
- R8: Both rows of a pair use the posterior as it stood before the pair. The new posterior is sat(old + sum over both rows of (new message - previous message)), and it is written in bit order.
- R9: Every saturation clamps to the symmetric range -(2^(W-1)-1) .. 2^(W-1)-1, which is ±31 for W=6, and a posterior never holds -2^(W-1).
- R10: Every start clears all stored check-to-bit messages to 0. hard_bits[j*Z+b] is the sign bit of the posterior of bit b in column j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Write load_data into a posterior column (idle only) |
| load_col | input | $clog2(NB) | Column to load |
| load_data | input | Z*W | Z signed LLRs, lane k at [k*W +: W] |
| rd_col | input | $clog2(NB) | Column to read |
| rd_data | output | Z*W | Posterior of column rd_col |
| iter_count | input | IW | Number of full iterations, taken at start |
| start | input | 1 | Begin decoding (idle only) |
| busy | output | 1 | Core is running or strobing done |
| done | output | 1 | One-cycle completion strobe |
| hard_bits | output | NB*Z | Sign of every posterior |

## Verification
A wrong rotation, a wrong min-sum selection or a bad merge corrupts the posterior of the affected column. That error reaches rd_data and hard_bits at the end of that column's apply cycle, at most 2*NB+1 cycles into the pair. The bench therefore compares every lane against an independent layered model after each run.

A fault in the sequencer shows up in other ways. It can shift the done cycle away from its exact count, or break the single-cycle shape of done. A wrong pair order or stale messages from an earlier run give posteriors that differ from the model within one iteration. Loads that leak through during busy show up the same way.

// File: rtl/ldpc_pkg.sv
package ldpc_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_GATHER,
        SEQ_APPLY,
        SEQ_ADVANCE,
        SEQ_DONE
    } seq_state_t;

    // symmetric clamp to [-lim, lim]
    function automatic int clamp_sym(input int x, input int lim);
        if (x > lim)  return lim;
        if (x < -lim) return -lim;
        return x;
    endfunction

endpackage

// File: rtl/ldpc_rotator.sv
module ldpc_rotator #(
    parameter int Z    = 4,
    parameter int EW   = 6,
    parameter bit BACK = 1'b0,
    localparam int SW  = (Z > 1) ? $clog2(Z) : 1
) (
    input  logic [SW-1:0]        amt,
    input  logic signed [EW-1:0] din  [Z],
    output logic signed [EW-1:0] dout [Z]
);

    for (genvar k = 0; k < Z; k++) begin : g_lane
        logic [SW-1:0] src;
        always_comb begin
            int idx;
            if (BACK) idx = k - int'(amt);
            else      idx = k + int'(amt);
            if (idx >= Z) idx = idx - Z;
            if (idx < 0)  idx = idx + Z;
            src = SW'(idx);
        end
        assign dout[k] = din[src];
    end

endmodule

// File: rtl/ldpc_minsum_row.sv
module ldpc_minsum_row #(
    parameter int Z  = 4,
    parameter int W  = 6,
    parameter int NB = 4,
    localparam int CW = (NB > 1) ? $clog2(NB) : 1,
    localparam int MW = W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gather,
    input  logic                active,
    input  logic [CW-1:0]       col,
    input  logic signed [W-1:0] v2c     [Z],
    output logic signed [W-1:0] c2v_new [Z]
);

    localparam logic [MW-1:0] MAXM = '1;

    logic first;
    assign first = gather && (col == '0);

    for (genvar k = 0; k < Z; k++) begin : g_lane
        logic [MW-1:0]       min1_q, min2_q, b1, b2, mag, pick;
        logic [CW-1:0]       idx_q, bidx;
        logic                sgn_q, bsgn;
        logic signed [W-1:0] mval;

        always_comb begin
            mag  = v2c[k][W-1] ? MW'(-v2c[k]) : MW'(v2c[k]);
            b1   = first ? MAXM : min1_q;
            b2   = first ? MAXM : min2_q;
            bidx = first ? '0   : idx_q;
            bsgn = first ? 1'b0 : sgn_q;
            pick = (idx_q == col) ? min2_q : min1_q;
            mval = {1'b0, pick};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                min1_q <= '0;
                min2_q <= '0;
                idx_q  <= '0;
                sgn_q  <= 1'b0;
            end else if (first || (gather && active)) begin
                min1_q <= b1;
                min2_q <= b2;
                idx_q  <= bidx;
                sgn_q  <= bsgn;
                if (gather && active) begin
                    sgn_q <= bsgn ^ v2c[k][W-1];
                    if (mag < b1) begin
                        min2_q <= b1;
                        min1_q <= mag;
                        idx_q  <= col;
                    end else if (mag < b2) begin
                        min2_q <= mag;
                    end
                end
            end
        end

        assign c2v_new[k] = (sgn_q ^ v2c[k][W-1]) ? -mval : mval;
    end

endmodule

// File: rtl/ldpc_merge.sv
module ldpc_merge
    import ldpc_pkg::*;
#(
    parameter int Z = 4,
    parameter int W = 6,
    localparam int DW  = W + 1,
    localparam int LIM = 2 ** (W - 1) - 1
) (
    input  logic signed [W-1:0]  post_in  [Z],
    input  logic signed [DW-1:0] delta_a  [Z],
    input  logic signed [DW-1:0] delta_b  [Z],
    output logic signed [W-1:0]  post_out [Z]
);

    for (genvar k = 0; k < Z; k++) begin : g_lane
        int total;
        always_comb total = int'(post_in[k]) + int'(delta_a[k]) + int'(delta_b[k]);
        assign post_out[k] = W'(clamp_sym(total, LIM));
    end

endmodule

// File: rtl/ldpc_dual_layer_core.sv
module ldpc_dual_layer_core
    import ldpc_pkg::*;
#(
    parameter int Z  = 4,
    parameter int MB = 4,
    parameter int NB = 4,
    parameter int W  = 6,
    parameter int IW = 4,
    parameter int SHIFT_TBL [MB*NB] = '{ 0,  1, -1,  2,
                                         3, -1,  0,  1,
                                        -1,  2,  1,  0,
                                         1,  0,  3, -1},
    localparam int P   = MB / 2,
    localparam int CW  = (NB > 1) ? $clog2(NB) : 1,
    localparam int RW  = (MB > 1) ? $clog2(MB) : 1,
    localparam int PW  = (P > 1)  ? $clog2(P)  : 1,
    localparam int SW  = (Z > 1)  ? $clog2(Z)  : 1,
    localparam int DW  = W + 1,
    localparam int LIM = 2 ** (W - 1) - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic [CW-1:0]   load_col,
    input  logic [Z*W-1:0]  load_data,
    input  logic [CW-1:0]   rd_col,
    output logic [Z*W-1:0]  rd_data,
    input  logic [IW-1:0]   iter_count,
    input  logic            start,
    output logic            busy,
    output logic            done,
    output logic [NB*Z-1:0] hard_bits
);

    function automatic int shift_of(input int r, input int c);
        int s;
        s = -1;
        for (int i = 0; i < MB * NB; i++)
            if (i == r * NB + c) s = SHIFT_TBL[i];
        return s;
    endfunction

    seq_state_t state_q, state_d;
    logic [CW-1:0] col_q;
    logic [PW-1:0] pair_q;
    logic [IW-1:0] iter_q, iter_lim_q;
    logic last_col, last_pair, last_iter;

    logic signed [W-1:0] post_q [NB][Z];
    logic signed [W-1:0] c2v_q  [MB][NB][Z];

    logic signed [W-1:0]       col_post [Z];
    logic signed [W-1:0]       merged   [Z];
    logic signed [DW-1:0]      delta_a  [Z];
    logic signed [DW-1:0]      delta_b  [Z];
    logic [1:0][Z-1:0][W-1:0]  newc_pk;
    logic [1:0][Z-1:0][DW-1:0] dbit_pk;
    logic [1:0][RW-1:0]        row_pk;
    logic [1:0]                act_pk;
    logic [NB*Z*W-1:0]         post_flat;

    assign last_col  = (col_q == CW'(NB - 1));
    assign last_pair = (pair_q == PW'(P - 1));
    assign last_iter = (iter_q == iter_lim_q - IW'(1));

    // ---------------- sequencer ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:    if (start) state_d = (iter_count == '0) ? SEQ_DONE : SEQ_GATHER;
            SEQ_GATHER:  if (last_col) state_d = SEQ_APPLY;
            SEQ_APPLY:   if (last_col) state_d = SEQ_ADVANCE;
            SEQ_ADVANCE: state_d = (last_pair && last_iter) ? SEQ_DONE : SEQ_GATHER;
            SEQ_DONE:    state_d = SEQ_IDLE;
            default:     state_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q != SEQ_IDLE);
        done = (state_q == SEQ_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q      <= '0;
            pair_q     <= '0;
            iter_q     <= '0;
            iter_lim_q <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: if (start) begin
                    col_q      <= '0;
                    pair_q     <= '0;
                    iter_q     <= '0;
                    iter_lim_q <= iter_count;
                end
                SEQ_GATHER, SEQ_APPLY: col_q <= last_col ? '0 : col_q + CW'(1);
                SEQ_ADVANCE: begin
                    if (last_pair) begin
                        pair_q <= '0;
                        iter_q <= iter_q + IW'(1);
                    end else begin
                        pair_q <= pair_q + PW'(1);
                    end
                end
                SEQ_DONE: ;
                default: ;
            endcase
        end
    end

    // ---------------- datapath ----------------
    for (genvar k = 0; k < Z; k++) begin : g_colsel
        assign col_post[k] = post_q[col_q][k];
    end

    for (genvar g = 0; g < 2; g++) begin : g_row
        localparam int OFS = g * P;
        logic [RW-1:0]        row_i;
        logic [SW-1:0]        amt;
        logic                 act;
        int                   sh;
        logic signed [W-1:0]  rot_v [Z];
        logic signed [W-1:0]  old_v [Z];
        logic signed [W-1:0]  v2c   [Z];
        logic signed [W-1:0]  newc  [Z];
        logic signed [DW-1:0] drot  [Z];
        logic signed [DW-1:0] dbit  [Z];

        assign row_i = RW'(int'(pair_q) + OFS);
        always_comb sh = shift_of(int'(pair_q) + OFS, int'(col_q));
        assign act = (sh >= 0);
        assign amt = SW'(sh);

        ldpc_rotator #(.Z(Z), .EW(W), .BACK(1'b0)) u_rot_fwd (
            .amt(amt), .din(col_post), .dout(rot_v)
        );

        for (genvar k = 0; k < Z; k++) begin : g_v
            assign old_v[k] = c2v_q[row_i][col_q][k];
            assign v2c[k]   = W'(clamp_sym(int'(rot_v[k]) - int'(old_v[k]), LIM));
            assign drot[k]  = DW'(int'(newc[k]) - int'(old_v[k]));
            assign newc_pk[g][k] = newc[k];
            assign dbit_pk[g][k] = act ? dbit[k] : '0;
        end

        ldpc_minsum_row #(.Z(Z), .W(W), .NB(NB)) u_cnu (
            .clk(clk), .rst_n(rst_n),
            .gather(state_q == SEQ_GATHER), .active(act),
            .col(col_q), .v2c(v2c), .c2v_new(newc)
        );

        ldpc_rotator #(.Z(Z), .EW(DW), .BACK(1'b1)) u_rot_back (
            .amt(amt), .din(drot), .dout(dbit)
        );

        assign row_pk[g] = row_i;
        assign act_pk[g] = act;
    end

    for (genvar k = 0; k < Z; k++) begin : g_dsel
        assign delta_a[k] = $signed(dbit_pk[0][k]);
        assign delta_b[k] = $signed(dbit_pk[1][k]);
    end

    ldpc_merge #(.Z(Z), .W(W)) u_merge (
        .post_in(col_post), .delta_a(delta_a), .delta_b(delta_b), .post_out(merged)
    );

    // ---------------- storage ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < NB; j++)
                for (int k = 0; k < Z; k++) post_q[j][k] <= '0;
            for (int r = 0; r < MB; r++)
                for (int j = 0; j < NB; j++)
                    for (int k = 0; k < Z; k++) c2v_q[r][j][k] <= '0;
        end else begin
            if (state_q == SEQ_IDLE && start)
                for (int r = 0; r < MB; r++)
                    for (int j = 0; j < NB; j++)
                        for (int k = 0; k < Z; k++) c2v_q[r][j][k] <= '0;
            if (state_q == SEQ_IDLE && load_en)
                for (int k = 0; k < Z; k++) post_q[load_col][k] <= load_data[k*W +: W];
            if (state_q == SEQ_APPLY) begin
                for (int k = 0; k < Z; k++) post_q[col_q][k] <= merged[k];
                for (int g = 0; g < 2; g++)
                    if (act_pk[g])
                        for (int k = 0; k < Z; k++)
                            c2v_q[row_pk[g]][col_q][k] <= newc_pk[g][k];
            end
        end
    end

    for (genvar j = 0; j < NB; j++) begin : g_out_col
        for (genvar k = 0; k < Z; k++) begin : g_out_lane
            assign post_flat[(j*Z+k)*W +: W] = post_q[j][k];
            assign hard_bits[j*Z+k]          = post_q[j][k][W-1];
        end
    end

    for (genvar k = 0; k < Z; k++) begin : g_rd
        assign rd_data[k*W +: W] = post_q[rd_col][k];
    end

endmodule

// File: rtl/ldpc_core_checker.sv
module ldpc_core_checker
    import ldpc_pkg::*;
#(
    parameter int Z  = 4,
    parameter int NB = 4,
    parameter int W  = 6,
    parameter int IW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input seq_state_t        state_q,
    input logic              load_en,
    input logic              start,
    input logic [IW-1:0]     iter_count,
    input logic              done,
    input logic [NB*Z*W-1:0] post_flat
);

    logic neg_limit;
    always_comb begin
        neg_limit = 1'b0;
        for (int i = 0; i < NB * Z; i++)
            if (post_flat[i*W +: W] == {1'b1, {(W-1){1'b0}}}) neg_limit = 1'b1;
    end

    a_r5_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_zero_iterations: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE && start && iter_count == '0) |=> done);

    a_r6_gather_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_GATHER) |=> $stable(post_flat));

    a_r3_busy_outside_apply_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_ADVANCE || state_q == SEQ_DONE) |=> $stable(post_flat));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE && !load_en) |=> $stable(post_flat));

    a_r9_symmetric_range: assert property (@(posedge clk) disable iff (!rst_n)
        !neg_limit);

endmodule

bind ldpc_dual_layer_core ldpc_core_checker #(.Z(Z), .NB(NB), .W(W), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .load_en(load_en), .start(start),
    .iter_count(iter_count), .done(done), .post_flat(post_flat)
);

// File: tb/ldpc_dual_layer_core_tb.sv
module ldpc_dual_layer_core_tb;

    localparam int Z = 4, MB = 4, NB = 4, W = 6, IW = 4;
    localparam int P = MB / 2, LIM = 31, CW = 2;
    localparam int TBL [MB*NB] = '{ 0,  1, -1,  2,
                                    3, -1,  0,  1,
                                   -1,  2,  1,  0,
                                    1,  0,  3, -1};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            load_en = 1'b0;
    logic [CW-1:0]   load_col = '0;
    logic [Z*W-1:0]  load_data = '0;
    logic [CW-1:0]   rd_col = '0;
    logic [Z*W-1:0]  rd_data;
    logic [IW-1:0]   iter_count = '0;
    logic            start = 1'b0;
    logic            busy, done;
    logic [NB*Z-1:0] hard_bits;

    int checks = 0;
    int fails  = 0;
    int mpost [NB][Z];
    int mc2v  [MB][NB][Z];

    ldpc_dual_layer_core #(.Z(Z), .MB(MB), .NB(NB), .W(W), .IW(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_col(load_col),
        .load_data(load_data), .rd_col(rd_col), .rd_data(rd_data),
        .iter_count(iter_count), .start(start), .busy(busy), .done(done),
        .hard_bits(hard_bits)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bsat(input int x);
        return (x > LIM) ? LIM : ((x < -LIM) ? -LIM : x);
    endfunction

    function automatic int absv(input int x);
        return (x < 0) ? -x : x;
    endfunction

    // independent layered model
    task automatic model_run(input int iters);
        int vv [2][NB][Z];
        int dsum [NB][Z];
        for (int r = 0; r < MB; r++)
            for (int j = 0; j < NB; j++)
                for (int k = 0; k < Z; k++) mc2v[r][j][k] = 0;
        for (int it = 0; it < iters; it++) begin
            for (int p = 0; p < P; p++) begin
                for (int j = 0; j < NB; j++)
                    for (int b = 0; b < Z; b++) dsum[j][b] = 0;
                for (int g = 0; g < 2; g++) begin
                    int r = p + g * P;
                    for (int j = 0; j < NB; j++) begin
                        int s = TBL[r*NB+j];
                        if (s >= 0)
                            for (int k = 0; k < Z; k++)
                                vv[g][j][k] = bsat(mpost[j][(k+s)%Z] - mc2v[r][j][k]);
                    end
                end
                for (int g = 0; g < 2; g++) begin
                    int r = p + g * P;
                    for (int j = 0; j < NB; j++) begin
                        int s = TBL[r*NB+j];
                        if (s >= 0)
                            for (int k = 0; k < Z; k++) begin
                                int mag = LIM;
                                int sg = 0;
                                int nc;
                                for (int j2 = 0; j2 < NB; j2++)
                                    if (j2 != j && TBL[r*NB+j2] >= 0) begin
                                        if (absv(vv[g][j2][k]) < mag) mag = absv(vv[g][j2][k]);
                                        if (vv[g][j2][k] < 0) sg ^= 1;
                                    end
                                nc = sg ? -mag : mag;
                                dsum[j][(k+s)%Z] += nc - mc2v[r][j][k];
                                mc2v[r][j][k] = nc;
                            end
                    end
                end
                for (int j = 0; j < NB; j++)
                    for (int b = 0; b < Z; b++) mpost[j][b] = bsat(mpost[j][b] + dsum[j][b]);
            end
        end
    endtask

    task automatic set_pattern(input int seed, input bit extreme);
        for (int j = 0; j < NB; j++)
            for (int k = 0; k < Z; k++) begin
                int i = j * Z + k;
                if (extreme) mpost[j][k] = ((i + seed) % 3 == 0) ? -LIM : LIM;
                else         mpost[j][k] = ((i * 37 + seed * 11) % 63) - 31;
            end
    endtask

    task automatic load_all();
        for (int j = 0; j < NB; j++) begin
            load_en  = 1'b1;
            load_col = CW'(j);
            for (int k = 0; k < Z; k++) load_data[k*W +: W] = W'(mpost[j][k]);
            @(posedge clk); #1;
        end
        load_en = 1'b0;
    endtask

    task automatic compare_all(input string req);
        for (int j = 0; j < NB; j++) begin
            rd_col = CW'(j);
            #1;
            for (int k = 0; k < Z; k++) begin
                int a = $signed(rd_data[k*W +: W]);
                chk(a == mpost[j][k], req, a, mpost[j][k]);
                chk(hard_bits[j*Z+k] == (mpost[j][k] < 0), "R10 hard decision",
                    int'(hard_bits[j*Z+k]), int'(mpost[j][k] < 0));
            end
        end
    endtask

    task automatic run_job(input int iters, input bit noisy, output int n);
        iter_count = IW'(iters);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        n = 0;
        chk(busy == 1'b1, "R5 busy after start", int'(busy), 1);
        while (!done && n < 2000) begin
            if (noisy && n < 12) begin
                load_en   = 1'b1;
                load_col  = CW'(n % NB);
                load_data = '1;
            end else begin
                load_en = 1'b0;
            end
            @(posedge clk); #1;
            n++;
        end
        load_en = 1'b0;
        @(posedge clk); #1;
        chk(done == 1'b0, "R5 done lasts one cycle", int'(done), 0);
        chk(busy == 1'b0, "R5 idle after done", int'(busy), 0);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(hard_bits == '0, "R1 hard_bits", int'(hard_bits), 0);
        for (int j = 0; j < NB; j++)
            for (int k = 0; k < Z; k++) mpost[j][k] = 0;
        compare_all("R1 reset posterior");
    endtask

    task automatic t_load();
        set_pattern(3, 1'b0);
        load_all();
        compare_all("R2 load readback");
    endtask

    task automatic t_zero_iters();
        int n;
        run_job(0, 1'b0, n);
        chk(n == 0, "R4 zero-iteration done latency", n, 0);
        compare_all("R4 posterior unchanged");
    endtask

    task automatic t_one_iter();
        int n;
        set_pattern(5, 1'b0);
        load_all();
        run_job(1, 1'b0, n);
        chk(n == P * (2 * NB + 1), "R5 one-iteration latency", n, P * (2 * NB + 1));
        model_run(1);
        compare_all("R8 R6 R7 single iteration");
    endtask

    task automatic t_multi_iter();
        int n;
        set_pattern(9, 1'b0);
        load_all();
        run_job(3, 1'b0, n);
        chk(n == 3 * P * (2 * NB + 1), "R5 three-iteration latency", n, 3 * P * (2 * NB + 1));
        model_run(3);
        compare_all("R5 R7 three iterations");
    endtask

    task automatic t_rerun_clears();
        int n;
        set_pattern(2, 1'b0);
        load_all();
        run_job(2, 1'b0, n);
        model_run(2);
        compare_all("R10 messages cleared on start");
    endtask

    task automatic t_saturation();
        int n;
        set_pattern(1, 1'b1);
        load_all();
        run_job(2, 1'b0, n);
        model_run(2);
        compare_all("R9 saturation");
    endtask

    task automatic t_busy_load();
        int n;
        set_pattern(7, 1'b0);
        load_all();
        run_job(2, 1'b1, n);
        model_run(2);
        compare_all("R3 load ignored while busy");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R5 watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_load();
        t_zero_iters();
        t_one_iter();
        t_multi_iter();
        t_rerun_clears();
        t_saturation();
        t_busy_load();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule